// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Bit Array

A cycle-level, synthesizable model of a square dynamic memory of single bits whose address reaches it in two halves over one shared bus. A falling row strobe picks a row, copies it whole into a row buffer, and leaves the array copy erased. Falling column strobes then read or write single bits in that buffer. A rising row strobe writes the buffer back. All strobes are sampled on the rising clock edge. Delays are whole clock cycles, not analog timings.

Each row also has an age counter. A row left untouched for a parameterised number of cycles loses its contents and raises a sticky error. A controller must refresh the rows, for example with row-strobe-only cycles. Column strobes given with no open row are ignored and clear the data output.

Top module: `dram_mux_array`

## Requirements
- R1: The array holds 2^ABITS rows of 2^ABITS bits each. A bit is addressed by its row half and then its column half, both presented on `addr`.
- R2: A strobe "falls" when it is sampled low on a rising edge after being sampled high on the previous edge. A falling `ras_n` captures `addr` as the row. A falling `cas_n` takes `addr` as the column.
- R3: On a falling `ras_n`, the addressed row is copied into the row buffer. On the same edge, the array copy of that row is cleared to all zeros.
- R4: A falling `cas_n` while a row is open and `ras_n` is low acts on the buffer bit. With `rw`=1 (read), `dout` takes that bit at the same edge. With `rw`=0 (write), the bit takes `din`, and a later read in the same row cycle returns it.
- R5: A rising `ras_n` while a row is open writes the whole buffer back into that array row and closes the row.
- R6: A row is touched when `ras_n` falls on it or while it is the open row. A row left untouched for RETAIN consecutive cycles is cleared to zeros and sets `retain_err`. Periodic row-strobe-only cycles prevent this.
- R7: A falling `cas_n` while no row is open, or while `ras_n` is high, changes no stored bit and drives `dout` to 0.
- R8: `dout` changes only on a read column strobe or an ignored column strobe; otherwise it holds its value.
- R9: Reset clears the array, the ages, `dout` and `retain_err`. Once set, `retain_err` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all strobes sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ABITS | Shared row/column address half |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| rw | input | 1 | 1 = read, 0 = write |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit |
| retain_err | output | 1 | Sticky retention-loss flag |

## Verification
A column read drives `dout` at the same rising edge that samples the falling `cas_n`. The bench therefore drives each strobe at a falling edge and samples `dout` at the next falling edge, which is half a cycle after the strobe was taken. Row copy, erase and write-back also land on the sampling edge, so they are judged later through reads of the same row in a fresh row cycle. The retention flag rises on the edge that completes RETAIN idle cycles. The bench checks it only after waiting clearly past that edge, and checks that it is still low after refresh passes spaced well inside that window.

// File: rtl/dram_mux_array.sv
module dram_mux_array #(
  parameter int ABITS  = 8,
  parameter int RETAIN = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ABITS-1:0] addr,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             rw,
  input  logic             din,
  output logic             dout,
  output logic             retain_err
);
  localparam int ROWS = 1 << ABITS;
  localparam int COLS = 1 << ABITS;
  localparam int AGE_W = $clog2(RETAIN + 1);
  localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(RETAIN);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(RETAIN - 1);

  logic [COLS-1:0]  mem [ROWS];
  logic [AGE_W-1:0] age [ROWS];
  logic [COLS-1:0]  rowbuf;
  logic [ABITS-1:0] row_lat;
  logic             row_open, ras_q, cas_q;

  wire ras_fall = !ras_n && ras_q;
  wire ras_rise = ras_n && !ras_q;
  wire cas_fall = !cas_n && cas_q;
  wire cas_ok   = row_open && !ras_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      row_open   <= 1'b0;
      row_lat    <= '0;
      rowbuf     <= '0;
      dout       <= 1'b0;
      retain_err <= 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        mem[r] <= '0;
        age[r] <= '0;
      end
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      for (int r = 0; r < ROWS; r++) begin
        if ((ras_fall && addr == ABITS'(r)) || (row_open && row_lat == ABITS'(r)))
          age[r] <= '0;
        else if (age[r] != AGE_MAX) begin
          age[r] <= age[r] + 1'b1;
          if (age[r] == AGE_LAST) begin
            mem[r]     <= '0;
            retain_err <= 1'b1;
          end
        end
      end
      if (ras_fall) begin
        row_lat   <= addr;
        rowbuf    <= mem[addr];
        mem[addr] <= '0;
        row_open  <= 1'b1;
      end else if (ras_rise && row_open) begin
        mem[row_lat] <= rowbuf;
        row_open     <= 1'b0;
      end
      if (cas_fall) begin
        if (!cas_ok)  dout         <= 1'b0;
        else if (rw)  dout         <= rowbuf[addr];
        else          rowbuf[addr] <= din;
      end
    end
  end

  assert_row_erased_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row_open |-> mem[row_lat] == '0);

  assert_read_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && cas_ok && rw) |=> dout == $past(rowbuf[addr]));

  assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && row_open) |=> mem[$past(row_lat)] == $past(rowbuf));

  assert_orphan_cas_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !cas_ok) |=> dout == 1'b0);

  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_fall |=> $stable(dout));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retain_err |=> retain_err);
endmodule

// File: tb/test_dram_mux_array.sv
module test_dram_mux_array;
  localparam int AB  = 3;
  localparam int N   = 1 << AB;
  localparam int RET = 600;

  logic clk = 1'b0, rst_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, rw = 1'b1, din = 1'b0;
  logic [AB-1:0] addr = '0;
  logic dout, retain_err;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_mux_array #(.ABITS(AB), .RETAIN(RET)) i_dram_mux_array (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .rw(rw), .din(din), .dout(dout), .retain_err(retain_err));

  function automatic logic pat(int r, int c);
    return logic'(((r * 5 + c * 3 + r * c) >> 1) & 1);
  endfunction

  function automatic logic want(int mode, int r, int c);
    if (mode == 0) return pat(r, c);
    if (mode == 1) return ~pat(r, c);
    return 1'b0;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic ras_open(int r);
    addr = AB'(r); ras_n = 1'b0; @(negedge clk);
  endtask

  task automatic ras_close();
    ras_n = 1'b1; @(negedge clk);
  endtask

  task automatic cas_op(int c, logic rwv, logic d, output logic q);
    addr = AB'(c); rw = rwv; din = d; cas_n = 1'b0;
    @(negedge clk);
    q = dout;
    cas_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_sweep(int mode);
    logic q;
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = 0; c < N; c++) cas_op(c, 1'b0, want(mode, r, c), q);
      ras_close();
    end
  endtask

  task automatic read_sweep(int mode, string tag);
    logic q;
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = 0; c < N; c++) begin
        cas_op(c, 1'b1, 1'b0, q);
        check(tag, q, want(mode, r, c), $sformatf("row %0d col %0d", r, c));
      end
      ras_close();
    end
  endtask

  task automatic refresh_all();
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      ras_close();
    end
  endtask

  initial begin
    logic q;
    repeat (3) @(negedge clk);
    check("R9", dout, 1'b0, "dout in reset");
    check("R9", retain_err, 1'b0, "retain_err in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5: full write then read-back in fresh row cycles
    write_sweep(0);
    read_sweep(0, "R1/R2/R3/R5");

    // R4: read, write inverse, re-read within one row cycle
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = 0; c < N; c++) begin
        cas_op(c, 1'b1, 1'b0, q);
        check("R4", q, pat(r, c), "read before modify");
        cas_op(c, 1'b0, ~pat(r, c), q);
        cas_op(c, 1'b1, 1'b0, q);
        check("R4", q, ~pat(r, c), "read after write same row cycle");
      end
      ras_close();
    end
    read_sweep(1, "R5");

    // R8: dout holds across write strobe, idle and row close
    ras_open(2);
    cas_op(1, 1'b1, 1'b0, q);
    check("R8", q, ~pat(2, 1), "setup read");
    cas_op(3, 1'b0, pat(2, 1), q);
    check("R8", q, ~pat(2, 1), "held over write strobe");
    repeat (4) @(negedge clk);
    check("R8", dout, ~pat(2, 1), "held over idle");
    ras_close();
    check("R8", dout, ~pat(2, 1), "held over row close");
    ras_open(2);
    cas_op(3, 1'b0, ~pat(2, 3), q);
    ras_close();

    // R7: column strobe with no open row
    ras_open(5);
    cas_op(0, 1'b1, 1'b0, q);
    ras_close();
    for (int k = 0; k < 2; k++) begin
      if (q !== 1'b1) begin
        ras_open(5);
        cas_op(k + 1, 1'b1, 1'b0, q);
        ras_close();
      end
    end
    cas_op(0, 1'b0, pat(5, 0), q);
    check("R7", q, 1'b0, "orphan write strobe zeroes dout");
    cas_op(4, 1'b1, 1'b0, q);
    check("R7", q, 1'b0, "orphan read strobe zeroes dout");
    read_sweep(1, "R7");

    // R6: refresh passes spaced inside the window keep data
    for (int k = 0; k < 6; k++) begin
      refresh_all();
      repeat (RET / 2) @(negedge clk);
    end
    check("R6", retain_err, 1'b0, "no loss with refresh");
    read_sweep(1, "R6");

    // R6 R9: neglect beyond the window
    repeat (RET + 20) @(negedge clk);
    check("R6", retain_err, 1'b1, "loss flagged");
    read_sweep(2, "R6");
    refresh_all();
    repeat (5) @(negedge clk);
    check("R9", retain_err, 1'b1, "flag sticky");

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", retain_err, 1'b0, "flag cleared by reset");
    read_sweep(2, "R9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule